// File: doc/BRIEF.md
# Configuration Port Master with Completion Watchdog

This block is a bus master that runs one read or one write at a time on a 16-bit parallel configuration port with an 8-bit address. A user request is taken with a valid/ready handshake. The block then issues a one-cycle enable on the port and holds the address, write data and direction on the port. It waits for the slave's completion strobe. Each request ends in exactly one response, which carries read data and a status bit: ok or timeout.

A slave may never strobe, for example when the access hits an unmapped location. A legitimate completion can also take anywhere from microseconds to milliseconds. For both reasons a 24-bit down-counter bounds every wait. Its limit is a run-time input that is captured when the request is accepted. When the limit runs out, the block closes the transaction with a timeout status and returns to idle. A strobe that arrives after that point is ignored. The master is cleared only by its own reset, so a reset of the surrounding transceiver logic never cuts off a pending access.

Top module: `cfg_port_master`

## Requirements
- R1: After reset, req_ready_o is 1, port_en_o is 0 and rsp_valid_o is 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. In the next cycle, and in that cycle only, port_en_o is 1. In that cycle port_addr_o, port_wdata_o and port_we_o (1 = write, 0 = read) show the accepted request.
- R3: port_addr_o, port_wdata_o and port_we_o hold their values from the enable cycle until the response is delivered.
- R4: req_ready_o is 0 from acceptance until the response handshake (rsp_valid_o and rsp_ready_i both 1). At most one transaction is outstanding.
- R5: A completion strobe (port_done_i = 1) in any of the limit+1 cycles that start with the enable cycle ends the transaction. If the strobe is in cycle k, counting the enable cycle as k = 0, rsp_valid_o is 1 from cycle k+1 and rsp_timeout_o is 0.
- R6: An ok read returns port_rdata_i as sampled in the strobe cycle. An ok write returns rsp_rdata_o = 0.
- R7: If no strobe arrives within those limit+1 cycles, rsp_valid_o rises in cycle limit+1 with rsp_timeout_o = 1 and rsp_rdata_o = 0, and the block then returns to idle.
- R8: limit_i is a 24-bit value sampled only at acceptance. Changing it during a transaction has no effect on that transaction.
- R9: A strobe while no transaction is waiting (idle, or a response pending, including a late strobe after a timeout) produces no response and changes no response field.
- R10: While rsp_valid_o is 1 and rsp_ready_i is 0, rsp_valid_o, rsp_rdata_o and rsp_timeout_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready for a request |
| req_addr_i | input | 8 | Request address |
| req_wdata_i | input | 16 | Request write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| limit_i | input | 24 | Timeout limit in cycles, sampled at acceptance |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_rdata_o | output | 16 | Read data (0 for writes and timeouts) |
| rsp_timeout_o | output | 1 | 1 = timed out, 0 = ok |
| port_en_o | output | 1 | One-cycle transaction enable |
| port_we_o | output | 1 | Write enable for the port |
| port_addr_o | output | 8 | Port address |
| port_wdata_o | output | 16 | Port write data |
| port_rdata_i | input | 16 | Port read data, valid with the strobe |
| port_done_i | input | 1 | Completion strobe |

## Verification
The assertions take for granted that the response side keeps rsp_ready_i meaningful only while a response is pending, and that the strobe input is a clean single-cycle pulse that is never X. The bench slave drives port_done_i and port_rdata_i only on falling edges and gives exactly one pulse per mapped access, after a chosen latency. The bench holds a response back for a random 0 to 3 cycles before accepting it, so the hold rule is exercised with both short and long stalls. The bench waits until any late strobe from the slave has fired before it issues the next request, so a stale strobe can only land while the master is idle or holding a response.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } cfgm_state_e;
endpackage

// File: rtl/cfgm_watchdog.sv
module cfgm_watchdog #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= limit_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = run_i && (cnt_q == '0);

  // R7/R8: loaded value only moves down by one per waiting cycle
  p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/cfgm_ctrl.sv
module cfgm_ctrl
  import cfgm_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_write_i,
  input  logic          done_i,
  input  logic          expired_i,
  input  logic          rsp_ready_i,
  output logic          req_ready_o,
  output logic          port_en_o,
  output logic          port_we_o,
  output logic [AW-1:0] port_addr_o,
  output logic [DW-1:0] port_wdata_o,
  output logic          wd_load_o,
  output logic          wd_run_o,
  output logic          fin_ok_o,
  output logic          fin_to_o
);
  cfgm_state_e state_q, state_d;
  logic        accept;
  logic        en_q;
  logic        we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign wd_load_o   = accept;
  assign wd_run_o    = (state_q == ST_WAIT);
  // strobe wins over expiry in the same cycle
  assign fin_ok_o    = wd_run_o && done_i;
  assign fin_to_o    = wd_run_o && !done_i && expired_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)                  state_d = ST_WAIT;
      ST_WAIT: if (fin_ok_o || fin_to_o)    state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i)             state_d = ST_IDLE;
      default:                              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= accept;
      if (accept) begin
        we_q    <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign port_en_o    = en_q;
  assign port_we_o    = we_q;
  assign port_addr_o  = addr_q;
  assign port_wdata_o = wdata_q;

  p_en_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_o |=> !port_en_o);

  p_busy_no_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_o |-> !req_ready_o);

  p_hold_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !port_en_o) |->
      ($stable(port_addr_o) && $stable(port_wdata_o) && $stable(port_we_o)));
endmodule

// File: rtl/cfgm_resp.sv
module cfgm_resp #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fin_ok_i,
  input  logic          fin_to_i,
  input  logic          is_write_i,
  input  logic [DW-1:0] port_rdata_i,
  input  logic          rsp_ready_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_timeout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_rdata_o   <= '0;
      rsp_timeout_o <= 1'b0;
    end else if (fin_ok_i || fin_to_i) begin
      rsp_valid_o   <= 1'b1;
      rsp_rdata_o   <= (fin_ok_i && !is_write_i) ? port_rdata_i : '0;
      rsp_timeout_o <= fin_to_i;
    end else if (rsp_valid_o && rsp_ready_i) begin
      rsp_valid_o   <= 1'b0;
    end
  end

  p_to_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_timeout_o) |-> rsp_rdata_o == '0);

  p_rsp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_timeout_o)));

  p_no_fin_when_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(fin_ok_i || fin_to_i));
endmodule

// File: rtl/cfg_port_master.sv
module cfg_port_master #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             req_write_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [DW-1:0]    rsp_rdata_o,
  output logic             rsp_timeout_o,
  output logic             port_en_o,
  output logic             port_we_o,
  output logic [AW-1:0]    port_addr_o,
  output logic [DW-1:0]    port_wdata_o,
  input  logic [DW-1:0]    port_rdata_i,
  input  logic             port_done_i
);
  logic wd_load, wd_run, wd_expired, fin_ok, fin_to;

  cfgm_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_write_i  (req_write_i),
    .done_i       (port_done_i),
    .expired_i    (wd_expired),
    .rsp_ready_i  (rsp_ready_i),
    .req_ready_o  (req_ready_o),
    .port_en_o    (port_en_o),
    .port_we_o    (port_we_o),
    .port_addr_o  (port_addr_o),
    .port_wdata_o (port_wdata_o),
    .wd_load_o    (wd_load),
    .wd_run_o     (wd_run),
    .fin_ok_o     (fin_ok),
    .fin_to_o     (fin_to)
  );

  cfgm_watchdog #(.CNT_W(CNT_W)) u_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wd_load),
    .run_i     (wd_run),
    .limit_i   (limit_i),
    .expired_o (wd_expired)
  );

  cfgm_resp #(.DW(DW)) u_resp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fin_ok_i      (fin_ok),
    .fin_to_i      (fin_to),
    .is_write_i    (port_we_o),
    .port_rdata_i  (port_rdata_i),
    .rsp_ready_i   (rsp_ready_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_timeout_o (rsp_timeout_o)
  );
endmodule

// File: tb/cfg_port_master_bench.sv
module cfg_port_master_bench;
  localparam time CLK = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [7:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_write_i = 1'b0;
  logic [23:0] limit_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [15:0] rsp_rdata_o;
  logic        rsp_timeout_o;
  logic        port_en_o, port_we_o;
  logic [7:0]  port_addr_o;
  logic [15:0] port_wdata_o;
  logic [15:0] port_rdata_i = 16'hDEAD;
  logic        port_done_i = 1'b0;

  int tests = 0;
  int fails = 0;

  always #(CLK/2) clk_i = ~clk_i;

  cfg_port_master u_cfg_port_master (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_wdata_i,
    .req_write_i, .limit_i, .rsp_valid_o, .rsp_ready_i, .rsp_rdata_o,
    .rsp_timeout_o, .port_en_o, .port_we_o, .port_addr_o, .port_wdata_o,
    .port_rdata_i, .port_done_i
  );

  // behavioural slave: addresses >= 0xC0 never strobe
  logic [15:0] slv_mem [256];
  logic [15:0] exp_mem [256];
  int  slv_lat = 0;
  bit  pend_active = 0;
  int  pend_cnt = 0;
  logic [7:0] pend_addr = '0;

  function automatic bit is_mapped(input logic [7:0] a);
    return a < 8'hC0;
  endfunction

  always @(negedge clk_i) begin
    port_done_i  = 1'b0;
    port_rdata_i = 16'hDEAD;
    if (pend_active) begin
      if (pend_cnt == 0) begin
        port_done_i  = 1'b1;
        port_rdata_i = slv_mem[pend_addr];
        pend_active  = 0;
      end else pend_cnt--;
    end
    if (port_en_o && is_mapped(port_addr_o)) begin
      if (port_we_o) slv_mem[port_addr_o] = port_wdata_o;
      if (slv_lat == 0) begin
        port_done_i  = 1'b1;
        port_rdata_i = slv_mem[port_addr_o];
      end else begin
        pend_active = 1;
        pend_cnt    = slv_lat - 1;
        pend_addr   = port_addr_o;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [7:0] a, input logic [15:0] wd, input bit wr,
                     input int lim, input int lat, input bit poke_limit);
    bit exp_to;
    int exp_cyc;
    int cyc;
    logic [15:0] exp_rd;
    int stall;
    exp_to  = !is_mapped(a) || (lat > lim);
    exp_cyc = exp_to ? lim + 1 : lat + 1;
    if (wr && is_mapped(a)) exp_mem[a] = wd;
    exp_rd  = (exp_to || wr) ? 16'h0 : exp_mem[a];

    @(negedge clk_i);
    slv_lat     = lat;
    req_addr_i  = a;
    req_wdata_i = wd;
    req_write_i = wr;
    limit_i     = 24'(lim);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_addr_i  = ~a;
    req_wdata_i = ~wd;
    cyc = 0;
    check(port_en_o === 1'b1, "R2 en", port_en_o, 1);
    check(port_addr_o === a && port_wdata_o === wd && port_we_o === wr,
          "R2 fields", port_addr_o, a);
    check(req_ready_o === 1'b0, "R4 busy", req_ready_o, 0);
    if (poke_limit) limit_i = 24'($urandom_range(0, 3));  // R8
    while (rsp_valid_o !== 1'b1 && cyc <= lim + 5) begin
      @(negedge clk_i);
      cyc++;
      if (port_en_o !== 1'b0) check(0, "R2 single pulse", port_en_o, 0);
      if (port_addr_o !== a || port_wdata_o !== wd || port_we_o !== wr)
        check(0, "R3 hold", port_addr_o, a);
      if (req_ready_o !== 1'b0) check(0, "R4 ready low", req_ready_o, 0);
    end
    check(cyc == exp_cyc, exp_to ? "R7 timeout cycle R8" : "R5 completion cycle R8", cyc, exp_cyc);
    check(rsp_timeout_o === exp_to, exp_to ? "R7 status" : "R5 status", rsp_timeout_o, exp_to);
    check(rsp_rdata_o === exp_rd, exp_to ? "R7 rdata" : "R6 rdata", rsp_rdata_o, exp_rd);
    stall = $urandom_range(0, 3);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_i);
      if (rsp_valid_o !== 1'b1 || rsp_rdata_o !== exp_rd || rsp_timeout_o !== exp_to)
        check(0, "R10 hold R9", rsp_rdata_o, exp_rd);
      if (req_ready_o !== 1'b0) check(0, "R4 ready while pending", req_ready_o, 0);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    check(rsp_valid_o === 1'b0 && req_ready_o === 1'b1, "R4 release", rsp_valid_o, 0);
    while (pend_active || port_done_i) begin
      @(negedge clk_i);
      if (rsp_valid_o !== 1'b0) check(0, "R9 late strobe", rsp_valid_o, 0);
    end
    repeat (2) begin
      @(negedge clk_i);
      check(rsp_valid_o === 1'b0, "R9 no response", rsp_valid_o, 0);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) begin
      slv_mem[i] = 16'(i * 16'h0101 + 16'h1357);
      exp_mem[i] = slv_mem[i];
    end
    repeat (3) @(negedge clk_i);
    check(req_ready_o === 1'b1 && port_en_o === 1'b0 && rsp_valid_o === 1'b0,
          "R1 reset", {req_ready_o, port_en_o, rsp_valid_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o === 1'b1 && rsp_valid_o === 1'b0, "R1 after release", req_ready_o, 1);

    txn(8'h10, 16'hA5A5, 1, 8, 3, 0);       // R5 write ok
    txn(8'h10, 16'h0000, 0, 8, 2, 0);       // R6 read back
    txn(8'h11, 16'h0000, 0, 0, 0, 0);       // R5 zero limit, immediate strobe
    txn(8'h12, 16'h0000, 0, 0, 1, 0);       // R7 zero limit, late
    txn(8'h13, 16'h0000, 0, 6, 6, 0);       // R5 boundary
    txn(8'h14, 16'h0000, 0, 6, 7, 0);       // R7 boundary, R9 late strobe
    txn(8'hC3, 16'h0000, 0, 5, 0, 0);       // R7 unmapped
    txn(8'hFF, 16'h1234, 1, 4, 0, 0);       // R7 unmapped write
    txn(8'h15, 16'h0000, 0, 9, 7, 1);       // R8 limit changed mid-flight
    txn(8'h16, 16'hBEEF, 1, 20000, 15000, 1); // R8 long wait in wide counter
    txn(8'h16, 16'h0000, 0, 20, 4, 0);      // R6

    for (int n = 0; n < 80; n++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 7) == 0) ? 8'(8'hC0 + $urandom_range(0, 63))
                                      : 8'($urandom_range(0, 31));
      txn(a, 16'($urandom), 1'($urandom), $urandom_range(0, 30),
          $urandom_range(0, 34), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule